// File: doc/BRIEF.md
# Synchronous Trap Entry Unit

This block performs the register updates a small two-level hart (machine and user) needs when it takes a synchronous exception. The pipeline raises a one-cycle trap strobe together with the raw exception code, the address of the faulting instruction, the instruction word, the current privilege level and the delegation mask. The block decides which privilege level handles the trap and rewrites an environment-call code to name the level it came from. It then produces, in one registered cycle, three CSR writes at the handling level: the exception PC, the cause and the trap value. It also produces a PC redirect to that level's vector base.

The block keeps the captured data address of the most recent misaligned load or store. The memory stage loads this register through a write strobe. Every trap that is taken empties it. The trap value is chosen from the exception code: the faulting PC, the instruction word (trimmed to 16 bits when the instruction is compressed), the captured data address, or zero.

Top module: `trapEntry`

## Requirements
- R1: After reset, `csrWe` and `pcLoad` are low. They stay low until a trap strobe has been sampled.
- R2: A trap sampled on a rising edge raises `csrWe` and `pcLoad` for exactly the following cycle, with all outputs of that trap valid in that cycle. Back-to-back strobes give back-to-back results in order.
- R3: A raw code of 11 (environment call) is rewritten to 8 plus the current privilege, where privilege encodes user as 0 and machine as 3. All other codes pass through unchanged.
- R4: `epcData` is the faulting PC with bit 0 cleared when `COMPRESSED` is 1, and with bits 1:0 cleared when it is 0.
- R5: `causeData` carries the adjusted code in its low bits, and its top bit (the interrupt flag) is always 0.
- R6: For code 0 (instruction address misaligned), `tvalData` is the unmasked faulting PC.
- R7: For code 2 (illegal instruction), `tvalData` is the full 32-bit instruction when its bits 1:0 are 2'b11. Otherwise it is bits 15:0 of the instruction, zero-extended.
- R8: For code 3 (breakpoint), and for every code other than 0, 2, 4 and 6, `tvalData` is 0.
- R9: For codes 4 and 6 (load/store address misaligned), `tvalData` is the value held in the captured fault-address register. That register is loaded through `faultAddrWe`/`faultAddrIn`.
- R10: Taking any trap clears the captured fault-address register. The clear wins over a load in the same cycle, so a later code 4 or 6 trap with no new load reports 0.
- R11: A trap goes to user level when the current privilege is not machine and bit [adjusted code] of `delegMask` is set. Otherwise it goes to machine level. The CSR addresses are the user-level addresses 0x041 (epc), 0x042 (cause) and 0x043 (tval), ORed with the target privilege shifted left by 8. Machine level therefore uses 0x341, 0x342 and 0x343.
- R12: `nextPc` is the target level's vector base (`mVecBase` or `uVecBase`) with bits 1:0 cleared, and `newPriv` is the target privilege.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapValid | input | 1 | Trap strobe, one cycle per exception |
| rawCause | input | 5 | Raw exception code |
| curPriv | input | 2 | Current privilege (0 user, 3 machine) |
| faultPc | input | XLEN | Address of the faulting instruction |
| instrWord | input | 32 | Faulting instruction word |
| delegMask | input | XLEN | Exception delegation bits |
| faultAddrWe | input | 1 | Load strobe for the captured fault address |
| faultAddrIn | input | XLEN | Misaligned data address to capture |
| mVecBase | input | XLEN | Machine-level trap vector base |
| uVecBase | input | XLEN | User-level trap vector base |
| csrWe | output | 1 | The three CSR writes are valid |
| epcAddr | output | 12 | CSR address for the exception PC |
| epcData | output | XLEN | Masked exception PC |
| causeAddr | output | 12 | CSR address for the cause |
| causeData | output | XLEN | Cause value |
| tvalAddr | output | 12 | CSR address for the trap value |
| tvalData | output | XLEN | Trap value |
| pcLoad | output | 1 | Redirect strobe |
| nextPc | output | XLEN | Redirect target |
| newPriv | output | 2 | Privilege level that handles the trap |

## Verification
Every result of a trap (the CSR addresses and data, the redirect target and the new privilege) is due exactly one cycle after the edge that samples the strobe. A fault-address load takes effect at its own edge and shows up only in the trap value of a later trap. The driver changes inputs on falling edges and queues the expected result as it raises the strobe. The monitor checks outputs on the next falling edge, where `csrWe` must be high with a queued item waiting. Any `csrWe` with an empty queue, or any item left in the queue at the end, counts as a timing failure.

// File: rtl/trapPkg.sv
package trapPkg;
  localparam int CAUSE_W = 5;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_M = 2'd3;
  localparam logic [11:0] ADDR_EPC_U   = 12'h041;
  localparam logic [11:0] ADDR_CAUSE_U = 12'h042;
  localparam logic [11:0] ADDR_TVAL_U  = 12'h043;

  typedef enum logic [1:0] {
    TV_ZERO  = 2'd0,
    TV_PC    = 2'd1,
    TV_INSTR = 2'd2,
    TV_FAULT = 2'd3
  } tvalSelE;

  typedef struct packed {
    logic               take;
    logic               toUser;
    tvalSelE            tvalSel;
    logic [CAUSE_W-1:0] adjCause;
  } trapCtlS;
endpackage

// File: rtl/trapCtrl.sv
module trapCtrl
  import trapPkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapValid,
  input  logic [CAUSE_W-1:0] rawCause,
  input  logic [1:0]         curPriv,
  input  logic [XLEN-1:0]    delegMask,
  output trapCtlS            ctl
);
  localparam logic [CAUSE_W-1:0] ECALL_RAW  = CAUSE_W'(11);
  localparam logic [CAUSE_W-1:0] ECALL_BASE = CAUSE_W'(8);

  logic [CAUSE_W-1:0] adjCause;
  logic               delegBit;

  always_comb begin
    if (rawCause == ECALL_RAW) adjCause = ECALL_BASE + CAUSE_W'(curPriv);
    else                       adjCause = rawCause;
  end

  always_comb begin
    delegBit = 1'b0;
    if (int'(adjCause) < XLEN) delegBit = delegMask[adjCause];
  end

  always_comb begin
    ctl.take     = trapValid;
    ctl.adjCause = adjCause;
    ctl.toUser   = (curPriv != PRIV_M) && delegBit;
    unique case (adjCause)
      CAUSE_W'(0):              ctl.tvalSel = TV_PC;
      CAUSE_W'(2):              ctl.tvalSel = TV_INSTR;
      CAUSE_W'(4), CAUSE_W'(6): ctl.tvalSel = TV_FAULT;
      default:                  ctl.tvalSel = TV_ZERO;
    endcase
  end

  // R11: machine mode never hands a trap down
  a_r11_machine_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && curPriv == PRIV_M) |-> !ctl.toUser);
  // R3: the rewritten code never stays at the raw environment-call value from user mode
  a_r3_ecall_user: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && rawCause == ECALL_RAW && curPriv == PRIV_U) |-> ctl.adjCause == ECALL_BASE);
endmodule

// File: rtl/trapDatapath.sv
module trapDatapath
  import trapPkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit COMPRESSED = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  trapCtlS         ctl,
  input  logic [XLEN-1:0] faultPc,
  input  logic [31:0]     instrWord,
  input  logic            faultAddrWe,
  input  logic [XLEN-1:0] faultAddrIn,
  input  logic [XLEN-1:0] mVecBase,
  input  logic [XLEN-1:0] uVecBase,
  output logic            csrWe,
  output logic [11:0]     epcAddr,
  output logic [XLEN-1:0] epcData,
  output logic [11:0]     causeAddr,
  output logic [XLEN-1:0] causeData,
  output logic [11:0]     tvalAddr,
  output logic [XLEN-1:0] tvalData,
  output logic            pcLoad,
  output logic [XLEN-1:0] nextPc,
  output logic [1:0]      newPriv
);
  localparam logic [XLEN-1:0] PC_MASK  = COMPRESSED ? ~XLEN'(1) : ~XLEN'(3);
  localparam logic [XLEN-1:0] VEC_MASK = ~XLEN'(3);

  logic [XLEN-1:0] faultQ;
  logic [XLEN-1:0] tvalNext;
  logic [XLEN-1:0] instrVal;
  logic [1:0]      destPriv;
  logic [11:0]     privOr;

  always_comb begin
    if (instrWord[1:0] == 2'b11) instrVal = XLEN'(instrWord);
    else                         instrVal = XLEN'(instrWord[15:0]);
  end

  always_comb begin
    unique case (ctl.tvalSel)
      TV_PC:    tvalNext = faultPc;
      TV_INSTR: tvalNext = instrVal;
      TV_FAULT: tvalNext = faultQ;
      default:  tvalNext = '0;
    endcase
  end

  assign destPriv = ctl.toUser ? PRIV_U : PRIV_M;
  assign privOr   = {2'b00, destPriv, 8'h00};

  always_ff @(posedge clk) begin
    if (!rstN)                faultQ <= '0;
    else if (ctl.take)        faultQ <= '0;
    else if (faultAddrWe)     faultQ <= faultAddrIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csrWe     <= 1'b0;
      pcLoad    <= 1'b0;
      epcAddr   <= '0;
      epcData   <= '0;
      causeAddr <= '0;
      causeData <= '0;
      tvalAddr  <= '0;
      tvalData  <= '0;
      nextPc    <= '0;
      newPriv   <= PRIV_M;
    end else begin
      csrWe  <= ctl.take;
      pcLoad <= ctl.take;
      if (ctl.take) begin
        epcAddr   <= ADDR_EPC_U | privOr;
        epcData   <= faultPc & PC_MASK;
        causeAddr <= ADDR_CAUSE_U | privOr;
        causeData <= XLEN'(ctl.adjCause);
        tvalAddr  <= ADDR_TVAL_U | privOr;
        tvalData  <= tvalNext;
        nextPc    <= (ctl.toUser ? uVecBase : mVecBase) & VEC_MASK;
        newPriv   <= destPriv;
      end
    end
  end

  // R5: interrupt flag of a written cause is always clear
  a_r5_int_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    csrWe |-> !causeData[XLEN-1]);
  // R4: exception PC honours the alignment mask
  a_r4_epc_aligned: assert property (@(posedge clk) disable iff (!rstN)
    csrWe |-> (epcData & ~PC_MASK) == '0);
  // R10: captured address is empty right after a trap
  a_r10_fault_cleared: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |=> faultQ == '0);
  // R12: redirect target is word aligned
  a_r12_vec_aligned: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> nextPc[1:0] == 2'b00);
  // R11: all three writes target the same level
  a_r11_same_level: assert property (@(posedge clk) disable iff (!rstN)
    csrWe |-> (epcAddr[9:8] == tvalAddr[9:8] && causeAddr[9:8] == epcAddr[9:8]
               && epcAddr[9:8] == newPriv));
  // R2: writes and redirect pulse together
  a_r2_paired_strobes: assert property (@(posedge clk) disable iff (!rstN)
    csrWe == pcLoad);
endmodule

// File: rtl/trapEntry.sv
module trapEntry
  import trapPkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit COMPRESSED = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapValid,
  input  logic [CAUSE_W-1:0] rawCause,
  input  logic [1:0]         curPriv,
  input  logic [XLEN-1:0]    faultPc,
  input  logic [31:0]        instrWord,
  input  logic [XLEN-1:0]    delegMask,
  input  logic               faultAddrWe,
  input  logic [XLEN-1:0]    faultAddrIn,
  input  logic [XLEN-1:0]    mVecBase,
  input  logic [XLEN-1:0]    uVecBase,
  output logic               csrWe,
  output logic [11:0]        epcAddr,
  output logic [XLEN-1:0]    epcData,
  output logic [11:0]        causeAddr,
  output logic [XLEN-1:0]    causeData,
  output logic [11:0]        tvalAddr,
  output logic [XLEN-1:0]    tvalData,
  output logic               pcLoad,
  output logic [XLEN-1:0]    nextPc,
  output logic [1:0]         newPriv
);
  trapCtlS ctl;

  trapCtrl #(.XLEN(XLEN)) uCtrl (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .rawCause(rawCause),
    .curPriv(curPriv), .delegMask(delegMask), .ctl(ctl)
  );

  trapDatapath #(.XLEN(XLEN), .COMPRESSED(COMPRESSED)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .faultPc(faultPc), .instrWord(instrWord),
    .faultAddrWe(faultAddrWe), .faultAddrIn(faultAddrIn),
    .mVecBase(mVecBase), .uVecBase(uVecBase),
    .csrWe(csrWe), .epcAddr(epcAddr), .epcData(epcData),
    .causeAddr(causeAddr), .causeData(causeData),
    .tvalAddr(tvalAddr), .tvalData(tvalData),
    .pcLoad(pcLoad), .nextPc(nextPc), .newPriv(newPriv)
  );

  // R2: a result follows every sampled strobe one cycle later
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> csrWe);
  // R1/R2: no result without a strobe in the cycle before
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |=> !csrWe);
  // R11: traps raised in machine mode land in machine mode
  a_r11_mach_result: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && curPriv == PRIV_M) |=> newPriv == PRIV_M);
endmodule

// File: tb/sim_trapEntry.sv
module sim_trapEntry;
  localparam int XLEN = 32;
  localparam logic [31:0] MVEC = 32'h0000_0107;
  localparam logic [31:0] UVEC = 32'h0000_2003;

  typedef struct packed {
    logic [11:0] epcA;   logic [31:0] epcD;
    logic [11:0] causeA; logic [31:0] causeD;
    logic [11:0] tvalA;  logic [31:0] tvalD;
    logic [31:0] npc;    logic [1:0]  priv;
  } expS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trapValid = 1'b0;
  logic [4:0] rawCause = '0;
  logic [1:0] curPriv = 2'd3;
  logic [31:0] faultPc = '0, instrWord = '0, delegMask = '0, faultAddrIn = '0;
  logic faultAddrWe = 1'b0;
  logic csrWe, pcLoad;
  logic [11:0] epcAddr, causeAddr, tvalAddr;
  logic [31:0] epcData, causeData, tvalData, nextPc;
  logic [1:0] newPriv;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] faultModel = '0;
  expS q[$];

  always #10 clk = ~clk;

  trapEntry #(.XLEN(XLEN), .COMPRESSED(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .rawCause(rawCause),
    .curPriv(curPriv), .faultPc(faultPc), .instrWord(instrWord),
    .delegMask(delegMask), .faultAddrWe(faultAddrWe), .faultAddrIn(faultAddrIn),
    .mVecBase(MVEC), .uVecBase(UVEC),
    .csrWe(csrWe), .epcAddr(epcAddr), .epcData(epcData),
    .causeAddr(causeAddr), .causeData(causeData),
    .tvalAddr(tvalAddr), .tvalData(tvalData),
    .pcLoad(pcLoad), .nextPc(nextPc), .newPriv(newPriv)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: raise one strobe on a falling edge and queue its expected result
  task automatic doTrap(input logic [4:0] c, input logic [1:0] p, input logic [31:0] pc,
                        input logic [31:0] ins, input logic [31:0] dm);
    expS e;
    logic [4:0] ac;
    logic toU;
    logic [11:0] lvl;
    @(negedge clk);
    rawCause = c; curPriv = p; faultPc = pc; instrWord = ins; delegMask = dm;
    trapValid = 1'b1;
    ac  = (c == 5'd11) ? 5'd8 + {3'b0, p} : c;                // R3
    toU = (p != 2'd3) && dm[ac];                               // R11
    lvl = toU ? 12'h000 : 12'h300;
    e.epcA = 12'h041 | lvl; e.causeA = 12'h042 | lvl; e.tvalA = 12'h043 | lvl;
    e.epcD = pc & 32'hFFFF_FFFE;                               // R4
    e.causeD = {27'd0, ac};                                    // R5
    case (ac)
      5'd0: e.tvalD = pc;                                      // R6
      5'd2: e.tvalD = (ins[1:0] == 2'b11) ? ins : {16'd0, ins[15:0]}; // R7
      5'd4, 5'd6: e.tvalD = faultModel;                        // R9
      default: e.tvalD = 32'd0;                                // R8
    endcase
    faultModel = '0;                                           // R10
    e.npc  = (toU ? UVEC : MVEC) & 32'hFFFF_FFFC;              // R12
    e.priv = toU ? 2'd0 : 2'd3;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    trapValid = 1'b0;
    faultAddrWe = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic capture(input logic [31:0] a);
    @(negedge clk);
    trapValid = 1'b0;
    faultAddrWe = 1'b1; faultAddrIn = a;
    faultModel = a;
    @(negedge clk);
    faultAddrWe = 1'b0;
  endtask

  // monitor: compare results on falling edges
  initial begin
    expS e;
    forever begin
      @(negedge clk);
      if (rstN && csrWe) begin
        if (q.size() == 0) begin
          chk("R2 unexpected csrWe", 32'd1, 32'd0);
        end else begin
          e = q.pop_front();
          chk("R2 pcLoad", {31'd0, pcLoad}, 32'd1);
          chk("R11 epcAddr", {20'd0, epcAddr}, {20'd0, e.epcA});
          chk("R11 causeAddr", {20'd0, causeAddr}, {20'd0, e.causeA});
          chk("R11 tvalAddr", {20'd0, tvalAddr}, {20'd0, e.tvalA});
          chk("R4 epcData", epcData, e.epcD);
          chk("R3 R5 causeData", causeData, e.causeD);
          chk("R6 R7 R8 R9 R10 tvalData", tvalData, e.tvalD);
          chk("R12 nextPc", nextPc, e.npc);
          chk("R12 newPriv", {30'd0, newPriv}, {30'd0, e.priv});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 csrWe in reset", {31'd0, csrWe}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 csrWe after reset", {31'd0, csrWe}, 32'd0);
    chk("R1 pcLoad after reset", {31'd0, pcLoad}, 32'd0);

    doTrap(5'd0, 2'd3, 32'h8000_0103, 32'h0, 32'h0);               // R6 misaligned fetch
    idle(1);
    doTrap(5'd2, 2'd3, 32'h8000_0200, 32'h1234_5673, 32'h0);       // R7 full word
    idle(1);
    doTrap(5'd2, 2'd0, 32'h8000_0204, 32'hABCD_4E02, 32'h0);       // R7 compressed
    idle(1);
    doTrap(5'd3, 2'd3, 32'h8000_0300, 32'h0010_0073, 32'h0);       // R8 breakpoint
    idle(1);
    doTrap(5'd11, 2'd0, 32'h0000_1000, 32'h0000_0073, 32'h0000_0100); // R3 R11 to user
    idle(1);
    doTrap(5'd11, 2'd3, 32'h8000_0400, 32'h0000_0073, 32'h0000_0800); // R3 R11 machine keeps
    idle(1);
    doTrap(5'd11, 2'd0, 32'h0000_1004, 32'h0000_0073, 32'h0);       // R3 user, not delegated
    idle(1);
    capture(32'h0000_1235);
    doTrap(5'd4, 2'd0, 32'h0000_1100, 32'h0, 32'h0000_0040);        // R9 load misaligned
    idle(1);
    doTrap(5'd6, 2'd0, 32'h0000_1104, 32'h0, 32'h0);                // R10 cleared value
    idle(1);
    capture(32'hDEAD_0009);
    doTrap(5'd6, 2'd0, 32'h0000_1108, 32'h0, 32'h0000_0040);        // R9 R11 delegated store
    idle(1);
    capture(32'h0000_0055);
    doTrap(5'd5, 2'd3, 32'h8000_0500, 32'h0, 32'h0);                // R8 other code
    idle(1);
    doTrap(5'd4, 2'd3, 32'h8000_0504, 32'h0, 32'h0);                // R10 cleared by cause 5
    idle(1);
    // R10: load and trap in the same cycle, clear wins
    @(negedge clk);
    faultAddrWe = 1'b1; faultAddrIn = 32'h0000_7777;
    doTrap(5'd13, 2'd3, 32'h8000_0600, 32'h0, 32'h0);
    idle(1);
    doTrap(5'd6, 2'd3, 32'h8000_0604, 32'h0, 32'h0);
    // R2: back-to-back strobes
    doTrap(5'd1, 2'd3, 32'h8000_0700, 32'h0, 32'h0);
    doTrap(5'd7, 2'd0, 32'h0000_0703, 32'h0, 32'h0000_0080);
    idle(3);
    chk("R2 queue drained", q.size(), 32'd0);
    chk("R2 csrWe idle", {31'd0, csrWe}, 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule